// File: doc/BRIEF.md
# Line Clamp Pulse Generator

This block produces one black-level clamp pulse per video line in the pixel clock domain. It brings a horizontal sync input into the clock domain and finds the end of each sync pulse, meaning the transition from the active level to the idle level. It then waits a programmed number of pixel clocks and drives the clamp output high for a second programmed number of pixel clocks. A polarity input states which sync level counts as active.

A mode input hands the output to an external clamp source. In that mode the internal delay and width settings and the sync input have no effect, and the output is a registered copy of the external clamp input. The output always comes from a flop, so it has no glitches.

Top module: `clampgen_top`

## Requirements
- R1: While `rst_n` is low, `clamp_out` is 0. After reset is released it stays 0 until a trailing sync edge has been timed.
- R2: With `ext_sel`=0, a trailing sync transition first sampled at rising edge n of `pclk` makes `clamp_out` go high after rising edge n+3+P. P is the effective placement. The two synchronizer flops, the edge stage and the output register account for the fixed offset.
- R3: Once high, `clamp_out` stays high for exactly D = `dur_cfg` clock cycles and then returns to 0.
- R4: A `place_cfg` of 0 behaves as a placement of 1. The values 1 to 255 are used as given.
- R5: A `dur_cfg` of 0 produces no clamp pulse on that line.
- R6: When `hs_pol`=1 the sync is active high, and when `hs_pol`=0 it is active low. Only the change from active to idle starts the timing. The leading edge of the sync pulse starts nothing.
- R7: A new trailing sync edge during the delay or during the pulse restarts the timing from the new edge. The output is 0 after edge n+3, where n is the edge at which the new transition is first sampled.
- R8: With `ext_sel`=1, `clamp_out` after each rising edge equals `ext_clamp_in` as sampled at that edge. In this mode `place_cfg`, `dur_cfg` and `hsync_in` are ignored and any pending internal timing is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hsync_in | input | 1 | Horizontal sync, asynchronous to `pclk` |
| hs_pol | input | 1 | Active sync level (1 = active high) |
| place_cfg | input | 8 | Clock cycles from the trailing sync edge to the clamp start |
| dur_cfg | input | 8 | Clamp width in clock cycles |
| ext_sel | input | 1 | 1 selects the external clamp source |
| ext_clamp_in | input | 1 | External clamp input |
| clamp_out | output | 1 | Registered clamp pulse |

## Verification
The hardest case to reach is a second trailing edge that lands inside an earlier line's timing window. It must arrive once in the delay phase and once in the pulse phase, and it must cut the earlier pulse at the right clock. The stimulus handles this with a long placement and width. It sends one sync pulse, then a second pulse whose end falls before the first clamp starts. It then sends a third pulse whose end falls after the clamp from the second pulse has begun. A per-cycle reference model predicts the output in every cycle, including the cycles where one pulse is cut short and the next is rescheduled. The extreme settings (placement 0, 1 and 255, width 0 and 255) and the active-low polarity after reset are covered the same way.

// File: rtl/clampgen_pkg.sv
package clampgen_pkg;

    // Phases of the per-line clamp timer.
    typedef enum logic [1:0] {
        TM_IDLE = 2'd0,
        TM_WAIT = 2'd1,
        TM_HOLD = 2'd2
    } tm_state_e;

    // Fewest synchronizer stages that the block accepts.
    localparam int SYNC_MIN_STAGES = 2;

endpackage

// File: rtl/clampgen_sync.sv
// Brings the sync into the clock domain, applies the polarity and flags the
// active-to-idle transition. The flag is qualified until the pipeline has filled.
module clampgen_sync #(
    parameter int STAGES = 2,
    localparam int WW = $clog2(STAGES + 2)
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic hs_raw_i,
    input  logic pol_i,
    output logic trail_o
);
    localparam logic [WW-1:0] WARM_FULL = WW'(STAGES + 1);
    localparam logic [WW-1:0] WARM_ONE  = WW'(1);

    typedef struct packed {
        logic [STAGES-1:0] pipe;
        logic              prev_act;
        logic [WW-1:0]     warm;
    } sync_t;

    sync_t s_d, s_q;
    logic  act_now;

    always_comb begin
        s_d = s_q;
        s_d.pipe[0] = hs_raw_i;
        for (int i = 1; i < STAGES; i++) begin
            s_d.pipe[i] = s_q.pipe[i-1];
        end
        act_now    = (s_q.pipe[STAGES-1] == pol_i);
        s_d.prev_act = act_now;
        if (s_q.warm != WARM_FULL) begin
            s_d.warm = s_q.warm + WARM_ONE;
        end
        trail_o = (s_q.warm == WARM_FULL) && s_q.prev_act && !act_now;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/clampgen_timer.sv
// Delay-then-hold timer started by each trailing sync edge.
module clampgen_timer #(
    parameter int CW = 8
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          trail_i,
    input  logic          hold_i,
    input  logic [CW-1:0] place_i,
    input  logic [CW-1:0] dur_i,
    output logic          active_o
);
    import clampgen_pkg::*;

    localparam logic [CW-1:0] CNT_ONE = CW'(1);

    typedef struct packed {
        tm_state_e     st;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (hold_i) begin
            t_d.st  = TM_IDLE;
            t_d.cnt = '0;
        end else if (trail_i) begin
            // a zero placement is taken as one
            t_d.st  = TM_WAIT;
            t_d.cnt = (place_i == '0) ? '0 : (place_i - CNT_ONE);
        end else begin
            unique case (t_q.st)
                TM_WAIT: begin
                    if (t_q.cnt == '0) begin
                        if (dur_i == '0) begin
                            t_d.st = TM_IDLE;
                        end else begin
                            t_d.st  = TM_HOLD;
                            t_d.cnt = dur_i - CNT_ONE;
                        end
                    end else begin
                        t_d.cnt = t_q.cnt - CNT_ONE;
                    end
                end
                TM_HOLD: begin
                    if (t_q.cnt == '0) begin
                        t_d.st = TM_IDLE;
                    end else begin
                        t_d.cnt = t_q.cnt - CNT_ONE;
                    end
                end
                default: begin
                    t_d.st  = TM_IDLE;
                    t_d.cnt = '0;
                end
            endcase
        end
        active_o = (t_q.st == TM_HOLD);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            t_q <= '{st: TM_IDLE, cnt: '0};
        end else begin
            t_q <= t_d;
        end
    end
endmodule

// File: rtl/clampgen_top.sv
module clampgen_top #(
    parameter int CW     = 8,
    parameter int STAGES = 2
) (
    input  logic          pclk,
    input  logic          rst_n,
    input  logic          hsync_in,
    input  logic          hs_pol,
    input  logic [CW-1:0] place_cfg,
    input  logic [CW-1:0] dur_cfg,
    input  logic          ext_sel,
    input  logic          ext_clamp_in,
    output logic          clamp_out
);
    typedef struct packed {
        logic clamp;
    } out_t;

    logic trail_w;
    logic tmr_active_w;
    out_t o_d, o_q;

    clampgen_sync #(.STAGES(STAGES)) u_sync (
        .clk_i    (pclk),
        .rst_ni   (rst_n),
        .hs_raw_i (hsync_in),
        .pol_i    (hs_pol),
        .trail_o  (trail_w)
    );

    clampgen_timer #(.CW(CW)) u_tmr (
        .clk_i    (pclk),
        .rst_ni   (rst_n),
        .trail_i  (trail_w),
        .hold_i   (ext_sel),
        .place_i  (place_cfg),
        .dur_i    (dur_cfg),
        .active_o (tmr_active_w)
    );

    always_comb begin
        o_d       = o_q;
        o_d.clamp = ext_sel ? ext_clamp_in : tmr_active_w;
        clamp_out = o_q.clamp;
    end

    always_ff @(posedge pclk or negedge rst_n) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end
endmodule

// File: rtl/clampgen_chk.sv
module clampgen_chk #(
    parameter int CW = 8
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          ext_sel_i,
    input logic          ext_clamp_i,
    input logic [CW-1:0] dur_i,
    input logic          trail_i,
    input logic          tmr_active_i,
    input logic          clamp_i
);
    // R8
    ext_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ext_sel_i |=> (clamp_i == $past(ext_clamp_i)));

    // R2
    clamp_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clamp_i && !$past(ext_sel_i)) |-> $past(tmr_active_i));

    // R7
    restart_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (trail_i && !ext_sel_i) |=> !tmr_active_i);

    // R5
    zero_dur_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(tmr_active_i) |-> ($past(dur_i) != '0));

    // R6
    single_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trail_i |=> !trail_i);
endmodule

bind clampgen_top clampgen_chk #(.CW(CW)) u_chk (
    .clk_i        (pclk),
    .rst_ni       (rst_n),
    .ext_sel_i    (ext_sel),
    .ext_clamp_i  (ext_clamp_in),
    .dur_i        (dur_cfg),
    .trail_i      (trail_w),
    .tmr_active_i (tmr_active_w),
    .clamp_i      (clamp_out)
);

// File: tb/sim_clampgen_top.sv
`timescale 1ns/1ps
module sim_clampgen_top;
    logic       pclk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hsync_in = 1'b0;
    logic       hs_pol = 1'b1;
    logic [7:0] place_cfg = 8'd5;
    logic [7:0] dur_cfg = 8'd4;
    logic       ext_sel = 1'b0;
    logic       ext_clamp_in = 1'b0;
    logic       clamp_out;

    int  cyc = 0;
    int  base = 0;
    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;
    string cur_tag = "R1";

    bit hs_h [0:8191];
    bit ex_h [0:8191];
    bit xi_h [0:8191];

    typedef struct {
        bit    exp;
        string tag;
        int    j;
    } item_t;
    item_t sb_q[$];

    always #4 pclk = ~pclk;

    clampgen_top u0 (
        .pclk         (pclk),
        .rst_n        (rst_n),
        .hsync_in     (hsync_in),
        .hs_pol       (hs_pol),
        .place_cfg    (place_cfg),
        .dur_cfg      (dur_cfg),
        .ext_sel      (ext_sel),
        .ext_clamp_in (ext_clamp_in),
        .clamp_out    (clamp_out)
    );

    function automatic bit is_act(bit h);
        return h == hs_pol;
    endfunction

    // Expected output sampled in cycle j, built from the requirements.
    function automatic bit model(int j);
        int pe;
        int dd;
        if (j - 1 < base) return 1'b0;
        if (ex_h[j-1]) return xi_h[j-1];                          // R8
        for (int m = j - 3; m <= j - 2; m++) begin
            if (m >= base && ex_h[m]) return 1'b0;
        end
        pe = (place_cfg == 8'd0) ? 1 : int'(place_cfg);            // R4
        for (int k = j - 4; k >= base + 1; k--) begin
            if (ex_h[k] || ex_h[k-1]) return 1'b0;
            if (is_act(hs_h[k-1]) && !is_act(hs_h[k])) begin       // R6
                dd = j - k;                                        // R2 R3 R7
                return (dd >= pe + 4) && (dd <= pe + 3 + int'(dur_cfg));
            end
        end
        return 1'b0;
    endfunction

    // Driver: queues the expected value for this cycle, then drives the inputs.
    task automatic step(bit h, bit e = 1'b0, bit x = 1'b0);
        item_t it;
        @(negedge pclk);
        it.exp = model(cyc);
        it.tag = cur_tag;
        it.j   = cyc;
        sb_q.push_back(it);
        hsync_in     = h;
        ext_sel      = e;
        ext_clamp_in = x;
        hs_h[cyc] = h;
        ex_h[cyc] = e;
        xi_h[cyc] = x;
        cyc++;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(!hs_pol);
    endtask

    task automatic pulse(int w);
        for (int i = 0; i < w; i++) step(hs_pol);
    endtask

    task automatic do_reset();
        @(negedge pclk);
        rst_n    = 1'b0;
        ext_sel  = 1'b0;
        hsync_in = !hs_pol;
        for (int i = 0; i < 3; i++) begin
            @(negedge pclk);
            checks++;
            if (clamp_out !== 1'b0) begin
                errors++;
                $display("FAIL R1 reset: clamp_out=%b expected=0", clamp_out);
            end
        end
        @(negedge pclk);
        rst_n = 1'b1;
        base  = cyc;
    endtask

    // Monitor: pops expected items and compares them with the port.
    initial begin
        item_t it;
        forever begin
            @(negedge pclk);
            #1;
            while (sb_q.size() > 0) begin
                it = sb_q.pop_front();
                checks++;
                if (clamp_out !== it.exp) begin
                    errors++;
                    $display("FAIL %s cycle %0d: clamp_out=%b expected=%b",
                             it.tag, it.j, clamp_out, it.exp);
                end
            end
        end
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1: reset state and quiet start, active-high sync
        hs_pol = 1'b1; place_cfg = 8'd5; dur_cfg = 8'd4;
        cur_tag = "R1";
        do_reset();
        idle(8);

        // R2 R3: basic line timing
        cur_tag = "R2_R3";
        pulse(8); idle(30);
        pulse(3); idle(25);

        // R4: zero placement acts as one
        cur_tag = "R4";
        place_cfg = 8'd0; dur_cfg = 8'd3;
        pulse(5); idle(20);

        // R5: zero duration gives no pulse
        cur_tag = "R5";
        place_cfg = 8'd3; dur_cfg = 8'd0;
        pulse(5); idle(20);

        // R2: largest placement
        cur_tag = "R2_max_place";
        place_cfg = 8'd255; dur_cfg = 8'd3;
        pulse(4); idle(270);

        // R3: longest pulse with smallest placement
        cur_tag = "R3_max_dur";
        place_cfg = 8'd1; dur_cfg = 8'd255;
        pulse(4); idle(270);

        // R7: restart during the delay, then during the pulse
        cur_tag = "R7";
        place_cfg = 8'd10; dur_cfg = 8'd20;
        pulse(4); idle(6);
        pulse(4); idle(17);
        pulse(3); idle(60);

        // R6: active-low sync after reset; leading edge starts nothing
        hs_pol = 1'b0; place_cfg = 8'd4; dur_cfg = 8'd5;
        cur_tag = "R6";
        do_reset();
        idle(8);
        pulse(6); idle(30);

        // R8: external source, settings and sync ignored
        cur_tag = "R8";
        place_cfg = 8'd2; dur_cfg = 8'd9;
        pulse(3);
        step(1'b1, 1'b1, 1'b0);
        step(1'b1, 1'b1, 1'b1);
        step(1'b0, 1'b1, 1'b1);
        step(1'b0, 1'b1, 1'b0);
        step(1'b1, 1'b1, 1'b0);
        step(1'b1, 1'b1, 1'b1);
        step(1'b1, 1'b1, 1'b0);
        for (int i = 0; i < 10; i++) step(1'b1, 1'b1, 1'b0);
        step(1'b1, 1'b1, 1'b1);
        step(1'b1, 1'b1, 1'b1);
        idle(20);

        // R8: back to internal timing
        cur_tag = "R8_return";
        pulse(4); idle(30);

        repeat (4) @(negedge pclk);
        #2;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule